// File: doc/BRIEF.md
# Asynchronous SRAM Bus Bridge

This block sits between a synchronous request port and an external asynchronous static RAM of one million 16-bit words. A requester presents a valid/ready transaction that carries a direction, a 20-bit word address, 16 bits of write data and a mask with one bit per byte lane. The bridge sequences the memory pins: two chip selects of opposite polarity, a write strobe, an output enable and one active-low enable per byte lane. It drives its half of the bidirectional data bus through a separate output-enable pin.

Reads hold the output enable low for a parameterized number of wait cycles. The read data is captured on the last of those cycles and returned with a one-cycle response pulse. Byte lanes that the mask leaves out return zero. A write has three phases: a setup cycle, a strobe held low for a parameterized number of cycles, and a hold cycle. Address, lane enables and data stay fixed through all three phases. The bridge never drives the bus while the memory's outputs are enabled. There is always a deselected cycle between a read and the next access. A request whose mask is all zero completes at once and never touches the memory.

Top module: `sram_bridge`

## Requirements
- R1: Out of reset, and whenever `req_ready` is high, the memory is deselected (`sram_ce1_n`=1, `sram_ce2`=0) with `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0. `req_ready` is low in the cycle after a request with a non-zero mask is accepted, and it stays low until that access has finished.
- R2: The two chip selects always change together. `sram_ce1_n`=0 occurs exactly when `sram_ce2`=1.
- R3: A read keeps the memory selected with `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD_WAIT consecutive cycles. `rsp_valid` pulses for one cycle in the cycle after the last of them.
- R4: Mask bit 0 selects data bits [7:0] and lane pin `sram_lane_n[0]`. Mask bit 1 selects bits [15:8] and `sram_lane_n[1]`. A lane pin is low only while the memory is selected and its mask bit is 1. In a read response, lanes with mask bit 0 are zero.
- R5: A write is one selected cycle with `sram_we_n`=1, then exactly WR_WAIT cycles with `sram_we_n`=0, then one selected cycle with `sram_we_n`=1. Address, lane enables and `sram_dq_o` do not change from setup through hold.
- R6: `sram_dq_oe` is high only during the three write phases, and `sram_oe_n` is high whenever `sram_dq_oe` is high.
- R7: In the cycle where `sram_oe_n` returns high after a read, the memory is deselected and `sram_dq_oe` is 0. The bus is therefore idle for at least one cycle before any following write drives it.
- R8: A request with an all-zero mask never pulls `sram_we_n` or `sram_oe_n` low, and `req_ready` stays high in the next cycle. For a read, `rsp_valid` pulses in the next cycle with `rsp_rdata`=0. For a write, memory contents are unchanged.
- R9: A write changes only the bytes whose mask bit is 1. Reading the word back returns the merged result of all earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, 1 = lane active |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, inactive lanes zero |
| sram_addr | output | 20 | Memory address pins |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low memory output enable |
| sram_lane_n | output | 2 | Active-low byte-lane enables |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Bridge drives the data bus when high |
| sram_dq_i | input | 16 | Data returned from the memory bus |

## Verification
The hardest case to reach from the ports is a write that follows a read with no gap, because that is where the bus turnaround rule can break. The scoreboard driver issues requests without spacing and starts each one as soon as `req_ready` rises. The monitor compares the pins in the cycle before the first driven cycle. The memory model fills disabled lanes with a fixed non-zero pattern, so a missing lane mask on reads produces wrong data. Back-to-back zero-mask requests check that the bridge completes them without moving any strobe.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } bstate_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/sram_bridge_wait_cnt.sv
module sram_bridge_wait_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_bridge_ctrl.sv
module sram_bridge_ctrl
  import sram_bridge_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  input  logic             cnt_last,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_en,
  output logic             capture,
  output bstate_t          state
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_WAIT - 1);

  bstate_t state_q;
  bstate_t state_d;
  logic    mask_none;

  assign mask_none = (req_mask == '0);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d  = state_q;
    rd_zero  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_en   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (mask_none) begin
            rd_zero = !req_write;
          end else if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_READ;
            cnt_load = 1'b1;
            cnt_val  = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (cnt_last) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        cnt_load = 1'b1;
        cnt_val  = WR_LOAD;
      end
      ST_WPULSE: begin
        if (cnt_last) begin
          state_d = ST_WHOLD;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/sram_bridge_dpath.sv
module sram_bridge_dpath
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_zero,
  input  logic              capture,
  input  bstate_t           state,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] pin_addr,
  output logic              pin_ce1_n,
  output logic              pin_ce2,
  output logic              pin_we_n,
  output logic              pin_oe_n,
  output logic [LANES-1:0]  pin_lane_n,
  output logic [DATA_W-1:0] pin_dq_o,
  output logic              pin_dq_oe
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              rsp_q;
  logic              selected;
  logic              rsp_load;

  // request registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  assign rsp_load = capture || rd_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= rsp_load;
    end
  end

  // per-lane capture with zero fill for masked-off lanes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
      byte_d = '0;
      if (capture && mask_q[g]) begin
        byte_d = dq_i[g*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (rsp_load) begin
        byte_q <= byte_d;
      end
    end

    assign rsp_rdata[g*BYTE_W +: BYTE_W] = byte_q;
    assign pin_lane_n[g] = !(selected && mask_q[g]);
  end

  assign selected  = (state != ST_IDLE);
  assign rsp_valid = rsp_q;
  assign pin_addr  = addr_q;
  assign pin_dq_o  = wdata_q;
  assign pin_ce1_n = !selected;
  assign pin_ce2   = selected;
  assign pin_we_n  = (state != ST_WPULSE);
  assign pin_oe_n  = (state != ST_READ);
  assign pin_dq_oe = (state == ST_WSETUP) || (state == ST_WPULSE) ||
                     (state == ST_WHOLD);

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/BYTE_W-1:0] req_mask,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        sram_addr,
  output logic                     sram_ce1_n,
  output logic                     sram_ce2,
  output logic                     sram_we_n,
  output logic                     sram_oe_n,
  output logic [DATA_W/BYTE_W-1:0] sram_lane_n,
  output logic [DATA_W-1:0]        sram_dq_o,
  output logic                     sram_dq_oe,
  input  logic [DATA_W-1:0]        sram_dq_i
);

  localparam int LANES    = DATA_W / BYTE_W;
  localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

  logic             accept;
  logic             rd_zero;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_en;
  logic             cnt_last;
  logic             capture;
  bstate_t          state;

  sram_bridge_ctrl #(
    .LANES  (LANES),
    .RD_WAIT(RD_WAIT),
    .WR_WAIT(WR_WAIT),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_mask (req_mask),
    .cnt_last (cnt_last),
    .req_ready(req_ready),
    .accept   (accept),
    .rd_zero  (rd_zero),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .cnt_en   (cnt_en),
    .capture  (capture),
    .state    (state)
  );

  sram_bridge_wait_cnt #(
    .CNT_W(CNT_W)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .en      (cnt_en),
    .last    (cnt_last)
  );

  sram_bridge_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rd_zero   (rd_zero),
    .capture   (capture),
    .state     (state),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .dq_i      (sram_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pin_addr  (sram_addr),
    .pin_ce1_n (sram_ce1_n),
    .pin_ce2   (sram_ce2),
    .pin_we_n  (sram_we_n),
    .pin_oe_n  (sram_oe_n),
    .pin_lane_n(sram_lane_n),
    .pin_dq_o  (sram_dq_o),
    .pin_dq_oe (sram_dq_oe)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [LANES-1:0]  req_mask,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce1_n,
  input logic              sram_ce2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [LANES-1:0]  sram_lane_n,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe
);

  p_rdy_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask != '0)) |=> !req_ready);

  p_ce_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce1_n |-> !sram_ce2);

  p_ce_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce1_n |-> sram_ce2);

  p_rsp_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!sram_oe_n) ||
                   $past(req_valid && req_ready && !req_write && (req_mask == '0))));

  p_rd_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_lane_n != '1));

  p_we_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |->
      ($stable(sram_addr) && $stable(sram_dq_o) && $stable(sram_lane_n)));

  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce1_n && sram_dq_oe && $stable(sram_addr)));

  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  p_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (sram_ce1_n && !sram_dq_oe));

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask == '0)) |=>
      (req_ready && sram_we_n && sram_oe_n));

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LANES (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_mask   (req_mask),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce1_n (sram_ce1_n),
  .sram_ce2   (sram_ce2),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_lane_n(sram_lane_n),
  .sram_dq_o  (sram_dq_o),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_bridge.sv
module test_sram_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int RD_WAIT    = 2;
  localparam int WR_WAIT    = 2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] sram_addr;
  logic        sram_ce1_n;
  logic        sram_ce2;
  logic        sram_we_n;
  logic        sram_oe_n;
  logic [1:0]  sram_lane_n;
  logic [15:0] sram_dq_o;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_i;

  int checks;
  int errors;
  int we_falls;
  int oe_falls;
  bit finished;

  logic [15:0] mem_arr [int unsigned];
  logic [15:0] ref_arr [int unsigned];
  logic [15:0] exp_q [$];

  sram_bridge #(
    .RD_WAIT(RD_WAIT),
    .WR_WAIT(WR_WAIT)
  ) i_sram_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_lane_n(sram_lane_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe),
    .sram_dq_i  (sram_dq_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = !clk;

  function automatic logic [15:0] lane_bits(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model: pins are stable between rising edges, so act at falling edge
  always @(negedge clk) begin
    logic sel;
    logic [15:0] word;
    sel = !sram_ce1_n && sram_ce2;
    word = mem_arr.exists(sram_addr) ? mem_arr[sram_addr] : 16'h0000;
    if (sel && !sram_we_n && sram_dq_oe) begin
      if (!sram_lane_n[0]) word[7:0]  = sram_dq_o[7:0];
      if (!sram_lane_n[1]) word[15:8] = sram_dq_o[15:8];
      mem_arr[sram_addr] = word;
    end
    sram_dq_i = 16'hEEEE;
    if (sel && !sram_oe_n && sram_we_n) begin
      if (!sram_lane_n[0]) sram_dq_i[7:0]  = word[7:0];
      if (!sram_lane_n[1]) sram_dq_i[15:8] = word[15:8];
    end
  end

  // monitor: pin protocol and scoreboard comparison
  int  we_run;
  int  oe_run;
  logic prev_we_n, prev_oe_n, prev_ce1_n, prev_dq_oe;
  logic [19:0] prev_addr;
  logic [15:0] prev_dq;
  always @(negedge clk) begin
    if (rst_n) begin
      check(sram_ce1_n == !sram_ce2, "R2 chip select pair", {sram_ce1_n, sram_ce2}, 0);
      if (sram_dq_oe)
        check(sram_oe_n, "R6 no bus contention", sram_oe_n, 1);
      if (!sram_oe_n)
        check(sram_lane_n != 2'b11, "R4 lanes enabled during read", sram_lane_n, 0);
      if (!sram_we_n && !prev_we_n)
        check(sram_addr == prev_addr && sram_dq_o == prev_dq, "R5 stable during strobe",
              {sram_addr, 12'h0}, {prev_addr, 12'h0});
      if (sram_we_n && !prev_we_n) begin
        check(we_run == WR_WAIT, "R5 strobe length", we_run, WR_WAIT);
        check(!sram_ce1_n && sram_dq_oe, "R5 hold cycle selected", {sram_ce1_n, sram_dq_oe}, 1);
      end
      if (sram_oe_n && !prev_oe_n) begin
        check(oe_run == RD_WAIT, "R3 read enable length", oe_run, RD_WAIT);
        check(sram_ce1_n && !sram_dq_oe, "R7 deselect after read", {sram_ce1_n, sram_dq_oe}, 2);
      end
      if (sram_dq_oe && !prev_dq_oe)
        check(prev_oe_n && prev_ce1_n, "R7 idle cycle before bus drive",
              {prev_oe_n, prev_ce1_n}, 3);
      if (!sram_we_n && prev_we_n) we_falls++;
      if (!sram_oe_n && prev_oe_n) oe_falls++;
      we_run = sram_we_n ? 0 : we_run + 1;
      oe_run = sram_oe_n ? 0 : oe_run + 1;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected response", rsp_rdata, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R4/R9 read data", rsp_rdata, e);
        end
      end
    end else begin
      we_run = 0;
      oe_run = 0;
    end
    prev_we_n  = sram_we_n;
    prev_oe_n  = sram_oe_n;
    prev_ce1_n = sram_ce1_n;
    prev_dq_oe = sram_dq_oe;
    prev_addr  = sram_addr;
    prev_dq    = sram_dq_o;
  end

  // driver: waits for ready, presents one request, records expectations
  task automatic do_req(input bit w, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] m);
    logic [15:0] cur;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    cur = ref_arr.exists(a) ? ref_arr[a] : 16'h0000;
    if (w) ref_arr[a] = (cur & ~lane_bits(m)) | (d & lane_bits(m));
    else   exp_q.push_back(cur & lane_bits(m));
    @(negedge clk);
    req_valid = 1'b0;
    if (m != 2'b00)
      check(!req_ready, "R1 ready low in flight", req_ready, 0);
    else
      check(req_ready, "R8 zero mask keeps ready", req_ready, 1);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || !req_ready) && n < 200) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int wf;
    int of;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    req_mask  = '0;
    sram_dq_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe
          && !rsp_valid, "R1 reset state",
          {req_ready, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid},
          7'b1101100);
    rst_n = 1'b1;

    // R9 full write, then partial lane merges
    do_req(1'b1, 20'h00010, 16'hA5C3, 2'b11);
    do_req(1'b0, 20'h00010, 16'h0000, 2'b11);
    do_req(1'b1, 20'h00010, 16'h1177, 2'b01);
    do_req(1'b0, 20'h00010, 16'h0000, 2'b11);
    do_req(1'b1, 20'h00010, 16'h9900, 2'b10);
    // R4 lane-masked reads
    do_req(1'b0, 20'h00010, 16'h0000, 2'b01);
    do_req(1'b0, 20'h00010, 16'h0000, 2'b10);
    drain();

    // R8 zero mask write and read never strobe the memory
    wf = we_falls;
    of = oe_falls;
    do_req(1'b1, 20'h00010, 16'hFFFF, 2'b00);
    do_req(1'b0, 20'h00010, 16'h0000, 2'b00);
    do_req(1'b0, 20'h00011, 16'h0000, 2'b00);
    drain();
    check(we_falls == wf && oe_falls == of, "R8 no strobe for empty mask",
          {we_falls[15:0], oe_falls[15:0]}, {wf[15:0], of[15:0]});
    do_req(1'b0, 20'h00010, 16'h0000, 2'b11);

    // R7 read immediately followed by write, address extremes
    do_req(1'b1, 20'hFFFFF, 16'h5A5A, 2'b11);
    do_req(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
    do_req(1'b1, 20'h00000, 16'h0F0F, 2'b11);
    do_req(1'b0, 20'h00000, 16'h0000, 2'b11);
    do_req(1'b1, 20'hFFFFF, 16'hC3C3, 2'b01);
    do_req(1'b0, 20'hFFFFF, 16'h0000, 2'b11);

    // R9 pattern sweep over several addresses
    for (int i = 0; i < 8; i++)
      do_req(1'b1, 20'h40000 + 20'(i * 37), 16'(16'h1234 * (i + 1)), 2'b11);
    for (int i = 0; i < 8; i++)
      do_req(1'b1, 20'h40000 + 20'(i * 37), 16'(16'hF00D ^ (i << 4)), 2'(i % 4));
    for (int i = 0; i < 8; i++)
      do_req(1'b0, 20'h40000 + 20'(i * 37), 16'h0000, 2'b11);
    drain();

    check(exp_q.size() == 0, "R3 all responses returned", exp_q.size(), 0);
    finish_run();
  end

endmodule